// File: doc/BRIEF.md
# Trace Capture Buffer with Pre-Trigger Window

This block records a stream of sample words into a circular memory and freezes the record around a trigger event. A programmable share of the record, in eighths, is kept from before the trigger. The rest is filled after it. Once a record is complete, a sequential read port returns the entries oldest first.

Three capture modes are available. Single mode waits for one trigger, keeps one record and stops. Continuous mode re-arms after each record has been read out and keeps going until a stop command arrives. Immediate mode fills one record at once and ignores the trigger. Samples can be taken on an internal strobe, or on a chosen edge of one of two external lines, optionally qualified by the other line being high.

An optional compression mode writes a sample only when it differs from the last written one. Each entry then carries a count of the samples skipped before it, so quiet stretches use no memory. The pre-trigger and post-trigger amounts are counted in written entries.

Top module: `trace_capture`

## Requirements
- R1: During and after reset, `done` is 0, `trig_addr` is 0, `rd_addr` is 0 and the block is idle.
- R2: The sample event is chosen by `src_sel`. A value of 0 uses `samp_stb`. A value of 1 uses an edge of `line_a`, and 2 or 3 uses an edge of `line_b`. An edge is a change of the selected line between two successive clock edges: rising when `edge_fall`=0 and falling when `edge_fall`=1. When `qual_en`=1, the event also needs the other line to be high in that cycle. The value of `din` in the event cycle is the value captured.
- R3: The pre-trigger length is P = DEPTH*`pre_eighths`/8 entries. The trigger entry is the first entry written in or after the cycle in which the trigger is accepted, and it lands at `trig_addr`. The record holds the P entries before the trigger entry, the trigger entry, and DEPTH-P-1 entries after it.
- R4: A trigger pulse that arrives before P entries have been written since arming is ignored. A trigger that arrives later, and finds no entry written in its cycle, is held until the next entry is written.
- R5: In single mode (`cmd_mode`=0 or 3), the block stops after one record. `done` stays 1, and later samples and triggers change neither the stored entries nor `trig_addr`.
- R6: In continuous mode (`cmd_mode`=1), reading the last of the DEPTH entries re-arms capture and drops `done`. A `cmd_stop` given while `done` is high keeps the record readable and prevents the re-arm.
- R7: In immediate mode (`cmd_mode`=2), the next DEPTH entries form the record, triggers are ignored, and `trig_addr` is 0.
- R8: With `comp_en`=1, the first sample after arming is always written. After that, a sample is written only when it differs from the last written value. The entry's `rd_ts` field holds the number of samples skipped before it, and `rd_data` holds the sample.
- R9: With `comp_en`=1, a sample that finds the skip count at its maximum (all ones) is written even if unchanged, carrying that maximum count.
- R10: With compression on, the pre-trigger and post-trigger amounts are counted in written entries, not in samples.
- R11: When `done` rises, `rd_addr` points at the oldest entry. Each `rd_next` moves to the next entry in time order, modulo DEPTH. `rd_data` and `rd_ts` show the entry at `rd_addr`.
- R12: `cmd_stop` during capture returns the block to idle. Later samples and triggers do not complete a record.
- R13: `cmd_go` is accepted only when the block is idle or holding a finished record. A `cmd_go` during capture has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| samp_stb | input | 1 | Internal sample strobe |
| line_a | input | 1 | External sample line A |
| line_b | input | 1 | External sample line B |
| src_sel | input | 2 | Sample event source |
| edge_fall | input | 1 | 1 selects falling edges, 0 selects rising edges |
| qual_en | input | 1 | Require the other line to be high |
| comp_en | input | 1 | Enable transition-only storage |
| pre_eighths | input | 3 | Pre-trigger share in eighths |
| din | input | W | Sample word |
| trig | input | 1 | Trigger pulse |
| cmd_go | input | 1 | Arm a capture in mode `cmd_mode` |
| cmd_mode | input | 2 | 0 single, 1 continuous, 2 immediate, 3 single |
| cmd_stop | input | 1 | Abort capture, end continuous operation |
| rd_next | input | 1 | Advance the read pointer |
| done | output | 1 | Record complete and readable |
| trig_addr | output | AW | Memory address of the trigger entry |
| rd_addr | output | AW | Current read address |
| rd_data | output | W | Sample of the entry at `rd_addr` |
| rd_ts | output | TSW | Skip count of the entry at `rd_addr` |

## Verification
The assertions check several properties on every cycle:
- the trigger address cannot move while the pre-trigger window is filling;
- an unchanged sample under compression leaves the write pointer alone;
- a saturated skip count clears on the next event;
- a held record keeps its read pointer and trigger address unless the reader advances;
- an immediate arm clears the trigger address.

Other properties can only be shown by the bench's scenarios, because each depends on whole records:
- where the trigger entry lands for each pre-trigger share;
- whether early triggers are held off;
- which samples each edge and qualifier setting selects;
- the exact entries and skip counts after compression;
- the re-arm and stop behaviour across two continuous records.

// File: rtl/trace_capture.sv
`timescale 1ns/1ps
module trace_capture #(
  parameter int W   = 8,
  parameter int AW  = 4,
  parameter int TSW = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           samp_stb,
  input  logic           line_a,
  input  logic           line_b,
  input  logic [1:0]     src_sel,
  input  logic           edge_fall,
  input  logic           qual_en,
  input  logic           comp_en,
  input  logic [2:0]     pre_eighths,
  input  logic [W-1:0]   din,
  input  logic           trig,
  input  logic           cmd_go,
  input  logic [1:0]     cmd_mode,
  input  logic           cmd_stop,
  input  logic           rd_next,
  output logic           done,
  output logic [AW-1:0]  trig_addr,
  output logic [AW-1:0]  rd_addr,
  output logic [W-1:0]   rd_data,
  output logic [TSW-1:0] rd_ts
);
  localparam int DEPTH = 1 << AW;
  localparam logic [TSW-1:0] TS_MAX = '1;
  localparam logic [AW:0] FULL = (AW+1)'(DEPTH);

  typedef enum logic [2:0] {IDLE, FILL, ARMED, POST, HOLD} st_t;
  st_t st;

  logic [W+TSW-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_cnt, pre_len;
  logic [AW:0]      cnt, rem;
  logic [TSW-1:0]   ts;
  logic [W-1:0]     last_d;
  logic pa, pb, first, pend, cont;
  logic cur, prv, oth, ev, cap, keep, wr, take, go_ok, rearm;

  assign pre_len = AW'((DEPTH * int'(pre_eighths)) >> 3);
  assign rem     = FULL - {1'b0, pre_len} - 1'b1;

  assign cur = (src_sel == 2'd1) ? line_a : line_b;
  assign prv = (src_sel == 2'd1) ? pa : pb;
  assign oth = (src_sel == 2'd1) ? line_b : line_a;
  assign ev  = (src_sel == 2'd0) ? samp_stb
             : ((edge_fall ? (prv & ~cur) : (~prv & cur)) & (~qual_en | oth));

  assign cap   = st inside {FILL, ARMED, POST};
  assign keep  = ~comp_en | first | (din != last_d) | (ts == TS_MAX);
  assign wr    = cap & ev & keep;
  assign take  = (st == ARMED) & (trig | pend) & wr;
  assign go_ok = cmd_go & ~cmd_stop & ((st == IDLE) | (st == HOLD));
  assign rearm = (st == HOLD) & cont & rd_next & (rd_cnt == AW'(DEPTH-1));

  assign done    = (st == HOLD);
  assign rd_data = mem[rd_addr][W-1:0];
  assign rd_ts   = mem[rd_addr][W+TSW-1:W];

  always_ff @(posedge clk)
    if (wr) mem[wr_ptr] <= {ts, din};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= IDLE; wr_ptr <= '0; cnt <= '0; ts <= '0; last_d <= '0;
      pa <= 1'b0; pb <= 1'b0; first <= 1'b1; pend <= 1'b0; cont <= 1'b0;
      trig_addr <= '0; rd_addr <= '0; rd_cnt <= '0;
    end else begin
      pa <= line_a;
      pb <= line_b;
      if (cmd_stop) begin
        cont <= 1'b0;
        pend <= 1'b0;
        if (cap) st <= IDLE;
      end else if (go_ok || rearm) begin
        wr_ptr <= '0; first <= 1'b1; ts <= '0; pend <= 1'b0;
        if (go_ok) cont <= (cmd_mode == 2'd1);
        if (go_ok && cmd_mode == 2'd2) begin
          st <= POST; cnt <= FULL; trig_addr <= '0;
        end else begin
          st <= (pre_len == '0) ? ARMED : FILL; cnt <= '0;
        end
      end else begin
        if (cap && ev) ts <= wr ? '0 : ts + 1'b1;
        if (wr) begin
          wr_ptr <= wr_ptr + 1'b1; first <= 1'b0; last_d <= din;
        end
        if (st == ARMED && trig) pend <= 1'b1;
        case (st)
          FILL: if (wr) begin
            cnt <= cnt + 1'b1;
            if (cnt + 1'b1 == {1'b0, pre_len}) st <= ARMED;
          end
          ARMED: if (take) begin
            trig_addr <= wr_ptr;
            pend <= 1'b0;
            if (rem == '0) begin
              st <= HOLD; rd_addr <= wr_ptr + 1'b1; rd_cnt <= '0;
            end else begin
              st <= POST; cnt <= rem;
            end
          end
          POST: if (wr) begin
            cnt <= cnt - 1'b1;
            if (cnt == 1) begin
              st <= HOLD; rd_addr <= wr_ptr + 1'b1; rd_cnt <= '0;
            end
          end
          HOLD: if (rd_next) begin
            rd_addr <= rd_addr + 1'b1; rd_cnt <= rd_cnt + 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  // R4
  fill_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st == FILL |=> $stable(trig_addr));
  // R7
  imm_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go_ok && cmd_mode == 2'd2 |=> trig_addr == '0 && st == POST);
  // R8
  comp_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap && ev && comp_en && !first && din == last_d && ts != TS_MAX && !cmd_stop
    |=> wr_ptr == $past(wr_ptr));
  // R9
  ts_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap && ev && ts == TS_MAX && !cmd_stop |=> ts == '0);
  // R5
  hold_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st == HOLD && !cmd_go && !rd_next |=> st == HOLD && $stable(rd_addr) && $stable(trig_addr));
  // R11
  rd_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st == HOLD && rd_next && !cmd_go && !cmd_stop && !cont |=> rd_addr == $past(rd_addr) + 1'b1);
endmodule

// File: tb/trace_capture_test.sv
`timescale 1ns/1ps
module trace_capture_test;
  localparam int W = 8, AW = 4, TSW = 3, D = 16;
  localparam int NR = 11;
  // mode, pre_eighths, comp, src, fall, qual, pattern, trigger index
  localparam int ROWS [NR][8] = '{
    '{0,4,0,0,0,0,0,10}, '{0,0,0,0,0,0,0,3},  '{0,7,0,0,0,0,5,20},
    '{0,2,0,0,0,0,1,9},  '{0,4,1,0,0,0,2,25}, '{2,4,0,0,0,0,0,2},
    '{2,0,1,0,0,0,2,0},  '{2,0,0,1,0,0,3,0},  '{2,0,0,1,1,0,3,0},
    '{2,0,0,2,1,1,4,0},  '{2,0,1,0,0,0,6,0}};

  logic clk = 0, rst_n = 0;
  always #2 clk = ~clk;

  logic samp_stb, line_a, line_b, edge_fall, qual_en, comp_en, trig;
  logic cmd_go, cmd_stop, rd_next, done;
  logic [1:0] src_sel, cmd_mode;
  logic [2:0] pre_eighths;
  logic [W-1:0] din, rd_data;
  logic [AW-1:0] trig_addr, rd_addr;
  logic [TSW-1:0] rd_ts;

  trace_capture #(.W(W), .AW(AW), .TSW(TSW)) uut (
    .clk(clk), .rst_n(rst_n), .samp_stb(samp_stb), .line_a(line_a), .line_b(line_b),
    .src_sel(src_sel), .edge_fall(edge_fall), .qual_en(qual_en), .comp_en(comp_en),
    .pre_eighths(pre_eighths), .din(din), .trig(trig), .cmd_go(cmd_go),
    .cmd_mode(cmd_mode), .cmd_stop(cmd_stop), .rd_next(rd_next), .done(done),
    .trig_addr(trig_addr), .rd_addr(rd_addr), .rd_data(rd_data), .rd_ts(rd_ts));

  int n_chk = 0, n_err = 0;
  logic [10:0] ent [0:511];
  int ent_n, rec_start, exp_ta;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic string rtag(input int r);
    case (r)
      0, 1, 3: return "R3";
      2:       return "R4";
      4:       return "R10";
      5:       return "R7";
      6:       return "R9";
      10:      return "R8";
      default: return "R2";
    endcase
  endfunction

  task automatic quiet();
    samp_stb = 0; line_a = 0; line_b = 0; din = '0; trig = 0;
  endtask

  task automatic drive(input int pat, input int t, input int i);
    samp_stb = 1; line_a = 0; line_b = 0; din = W'(i); trig = (i == t);
    case (pat)
      1: samp_stb = (i % 2) == 1;
      2: din = (i < 20) ? 8'(i / 3) : ((i < 35) ? 8'd99 : 8'(i));
      3: begin samp_stb = 0; line_a = ((i / 2) % 2) == 1; end
      4: begin samp_stb = 0; line_b = (i % 2) == 1; line_a = ((i / 5) % 2) == 1; end
      5: trig = (i == 2) || (i == t);
      6: din = 8'(i / 2);
      default: ;
    endcase
  endtask

  task automatic capture(input bit do_go, input int mode, input int frac, input int comp,
                         input int src, input int fall, input int qual, input int pat,
                         input int t, input string req);
    int pre, te, fin, last_i, k, mts;
    bit mpend, mfirst, pa_m, pb_m;
    logic [7:0] mlast;
    pre = (mode == 2) ? 0 : (D * frac) / 8;
    te = -1; last_i = -1; k = -1; mts = 0;
    mpend = 0; mfirst = 1; pa_m = 0; pb_m = 0; mlast = '0;
    fin = (mode == 2) ? D - 1 : -1;
    quiet();
    pre_eighths = 3'(frac); comp_en = comp[0]; src_sel = 2'(src);
    edge_fall = fall[0]; qual_en = qual[0];
    if (do_go) begin
      @(negedge clk); cmd_go = 1; cmd_mode = 2'(mode);
      @(negedge clk); cmd_go = 0;
    end
    ent_n = 0;
    for (int i = 0; i < 400; i++) begin
      if (done) begin k = i; break; end
      drive(pat, t, i);
      @(posedge clk);
      begin
        logic cur, prv, oth, ev, sto;
        int nb;
        cur = (src == 1) ? line_a : line_b;
        prv = (src == 1) ? pa_m : pb_m;
        oth = (src == 1) ? line_b : line_a;
        ev  = (src == 0) ? samp_stb
            : ((fall != 0 ? (prv && !cur) : (!prv && cur)) && (qual == 0 || oth));
        pa_m = line_a; pb_m = line_b;
        nb = ent_n; sto = 0;
        if (ev) begin
          if (comp == 0 || mfirst || din != mlast || mts == 7) begin
            ent[ent_n] = {3'(mts), din}; ent_n++;
            mts = 0; mfirst = 0; mlast = din; sto = 1;
          end else mts++;
        end
        if (mode != 2 && te < 0) begin
          if (trig && nb >= pre) mpend = 1;
          if (mpend && sto) begin te = nb; fin = te + D - pre - 1; end
        end
        if (sto && fin >= 0 && nb == fin) last_i = i;
      end
      @(negedge clk);
    end
    quiet();
    chk(k > 0 && k == last_i + 1, {req, " done cycle"}, k, last_i + 1);
    rec_start = (mode == 2) ? 0 : te - pre;
    exp_ta = (mode == 2) ? 0 : te % D;
    chk(int'(trig_addr) == exp_ta, {req, " trig_addr"}, int'(trig_addr), exp_ta);
  endtask

  task automatic readout(input string req);
    for (int j = 0; j < D; j++) begin
      int e;
      logic [14:0] ev_, av;
      e = rec_start + j;
      ev_ = {4'(e % D), ent[e]};
      av = {rd_addr, rd_ts, rd_data};
      chk(av == ev_, {"R11 ", req}, int'(av), int'(ev_));
      rd_next = 1;
      @(negedge clk);
      rd_next = 0;
    end
  endtask

  initial begin
    logic [AW-1:0] ta, ra;
    logic [W-1:0] rv;
    quiet();
    cmd_go = 0; cmd_stop = 0; cmd_mode = 0; rd_next = 0;
    src_sel = 0; edge_fall = 0; qual_en = 0; comp_en = 0; pre_eighths = 0;
    repeat (3) @(negedge clk);
    chk(!done && trig_addr == '0 && rd_addr == '0, "R1 in reset", int'(done), 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk(!done && trig_addr == '0 && rd_addr == '0, "R1 after reset", int'(done), 0);

    for (int r = 0; r < NR; r++) begin
      capture(1, ROWS[r][0], ROWS[r][1], ROWS[r][2], ROWS[r][3], ROWS[r][4],
              ROWS[r][5], ROWS[r][6], ROWS[r][7], rtag(r));
      readout(rtag(r));
    end

    // R5: a finished single record ignores further samples and triggers
    capture(1, 0, 4, 0, 0, 0, 0, 0, 10, "R5");
    readout("R5");
    ta = trig_addr; ra = rd_addr; rv = rd_data;
    for (int i = 0; i < 20; i++) begin drive(0, 3, i); @(negedge clk); end
    quiet();
    @(negedge clk);
    chk(done && trig_addr == ta && rd_addr == ra && rd_data == rv, "R5 frozen",
        int'(rd_data), int'(rv));

    // R6: continuous re-arm after readout, then stop while holding
    capture(1, 1, 4, 0, 0, 0, 0, 0, 10, "R6 first");
    readout("R6 first");
    chk(!done, "R6 re-arm", int'(done), 0);
    capture(0, 1, 4, 0, 0, 0, 0, 0, 12, "R6 second");
    cmd_stop = 1; @(negedge clk); cmd_stop = 0;
    readout("R6 second");
    chk(done, "R6 stop keeps record", int'(done), 1);

    // R13: go during capture is ignored
    pre_eighths = 3'd4; comp_en = 0; src_sel = 0; edge_fall = 0; qual_en = 0;
    cmd_go = 1; cmd_mode = 2'd0; @(negedge clk); cmd_go = 0;
    for (int i = 0; i < 3; i++) begin drive(0, -1, i); @(negedge clk); end
    cmd_go = 1; cmd_mode = 2'd2; drive(0, -1, 3); @(negedge clk); cmd_go = 0;
    for (int i = 4; i < 24; i++) begin drive(0, -1, i); @(negedge clk); end
    quiet();
    chk(!done, "R13 go ignored", int'(done), 0);
    cmd_stop = 1; @(negedge clk); cmd_stop = 0;

    // R12: stop aborts a capture
    pre_eighths = 3'd0;
    cmd_go = 1; cmd_mode = 2'd0; @(negedge clk); cmd_go = 0;
    for (int i = 0; i < 2; i++) begin drive(0, -1, i); @(negedge clk); end
    cmd_stop = 1; @(negedge clk); cmd_stop = 0;
    for (int i = 0; i < 30; i++) begin drive(0, 5, i); @(negedge clk); end
    quiet();
    chk(!done, "R12 stop aborts", int'(done), 0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #(4 * 150000);
    n_chk++; n_err++;
    $display("FAIL watchdog all requirements actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule